// File: doc/BRIEF.md
# Page Translation Table Unit

This block translates page-granular virtual addresses for several processor cores that share one table. The table holds one 16-bit word per virtual page of a fixed window. Each word has a truncated physical page number in its low bits and an enable bit directly above that field. Software maintains the words through a small register port. That port can read a word, write a raw word, map a page from a full physical address, or unmap a page by clearing only its enable bit.

A lookup port takes a virtual address. One cycle later it returns a status and, on success, the rebuilt physical address. The word keeps only the low part of the physical page number, because the cached and uncached views of the same page differ only in the upper address bits. The full address is therefore rebuilt by shifting the stored page number up by the page size and adding a fixed on-chip memory base. The table holds no permission or caching attributes, so the flags output is always zero.

Top module: `page_xlate_table`

## Requirements
- R1: After reset every word is zero, so a read of any index returns 0 and any in-window, aligned lookup reports status 2 (unmapped).
- R2: Register op 2 (write) stores reg_wdata[15:0] unchanged at reg_idx. Op 1 (read) returns the word at reg_idx on reg_rdata one cycle later, and reg_rdata holds its value otherwise. Op 0 does nothing.
- R3: Register op 3 (map) treats reg_wdata as a physical address. It stores bits [PAGE_SHIFT+PFN_W-1:PAGE_SHIFT] in word bits [PFN_W-1:0], sets bit PFN_W (enable), and clears every higher bit. Higher page-number bits are dropped.
- R4: Register op 4 (unmap) clears bit PFN_W of the word at reg_idx and leaves all its other bits unchanged.
- R5: A lookup uses the word at index (lk_va - VBASE) >> PAGE_SHIFT.
- R6: A lookup that hits a word with bit PFN_W set returns status 0 and rsp_pa = MEM_BASE + (word[PFN_W-1:0] << PAGE_SHIFT). Word bits above PFN_W have no effect.
- R7: A lookup that hits a word with bit PFN_W clear returns status 2 and rsp_pa = 0.
- R8: A lookup whose address has any of its low PAGE_SHIFT bits set, is below VBASE, or is at or above VBASE + (NUM_ENT << PAGE_SHIFT) returns status 1 and rsp_pa = 0.
- R9: rsp_flags is always zero.
- R10: rsp_valid is high exactly one cycle after lk_valid. A register change made in cycle N is seen by a lookup issued in cycle N+1, and a lookup issued in cycle N still sees the old word.
- R11: Register ops with reg_idx >= NUM_ENT change no word, and a read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_op | input | 3 | Register command: 0 none, 1 read, 2 write, 3 map, 4 unmap |
| reg_idx | input | RIDX_W | Word index for the register command |
| reg_wdata | input | PA_W | Raw word (low 16 bits) or physical address for map |
| reg_rdata | output | 16 | Word returned by a read |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_status | output | 2 | 0 ok, 1 bad address, 2 unmapped |
| rsp_pa | output | PA_W | Translated physical address, zero unless ok |
| rsp_flags | output | FLAG_W | Page attribute flags, always zero |

## Verification
The bench builds the block with a 9-bit page field, 4 KiB pages, a 32-entry window at a nonzero base, and an 8-bit register index. With a 9-bit field, a physical address only slightly above the field's reach already shows the truncation of the page number. With 32 entries, every word can be mapped and looked up in turn. The 8-bit index reaches past the table, so out-of-range register commands can be tried on indices whose low bits alias real entries. The window base is nonzero, so both edges of the range check, and an address below the base, are tested.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    localparam int ENTRY_W = 16;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_MAP   = 3'd3,
        OP_UNMAP = 3'd4
    } reg_op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BADADDR  = 2'd1,
        ST_UNMAPPED = 2'd2
    } xl_status_e;

    function automatic entry_t clear_enable(entry_t e, int en_pos);
        entry_t r;
        r = e;
        r[en_pos] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ptt_store.sv
module ptt_store
    import ptt_pkg::*;
#(
    parameter int NUM_ENT    = 64,
    parameter int PFN_W      = 9,
    parameter int PAGE_SHIFT = 12,
    parameter int PA_W       = 32,
    parameter int RIDX_W     = 8,
    localparam int IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_op_e           op,
    input  logic [RIDX_W-1:0] idx,
    input  logic [PA_W-1:0]   wdata,
    output entry_t            rdata,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [PFN_W:0]    lk_word
);

    entry_t            ent [NUM_ENT];
    logic              in_rng;
    logic [IDX_W-1:0]  widx;
    entry_t            map_word;
    logic              unused_wdata;

    assign in_rng = (int'(idx) < NUM_ENT);
    assign widx   = idx[IDX_W-1:0];
    assign unused_wdata = ^wdata;

    always_comb begin
        map_word = '0;
        map_word[PFN_W-1:0] = wdata[PAGE_SHIFT +: PFN_W];
        map_word[PFN_W]     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) ent[i] <= '0;
        end else if (in_rng) begin
            case (op)
                OP_WRITE: ent[widx] <= wdata[ENTRY_W-1:0];
                OP_MAP:   ent[widx] <= map_word;
                OP_UNMAP: ent[widx] <= clear_enable(ent[widx], PFN_W);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (op == OP_READ) begin
            rdata <= in_rng ? ent[widx] : '0;
        end
    end

    always_comb begin
        if (int'(lk_idx) < NUM_ENT) lk_word = ent[lk_idx][PFN_W:0];
        else                        lk_word = '0;
    end

endmodule

// File: rtl/ptt_vcheck.sv
module ptt_vcheck #(
    parameter int              VA_W       = 32,
    parameter int              PAGE_SHIFT = 12,
    parameter int              NUM_ENT    = 64,
    parameter logic [VA_W-1:0] VBASE      = 32'hA000_0000,
    localparam int             IDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [VA_W-1:0]  va,
    output logic             ok,
    output logic [IDX_W-1:0] idx
);

    logic [VA_W-1:0] off;
    logic [VA_W-1:0] pg;
    logic            aligned;
    logic            in_win;

    assign off     = va - VBASE;
    assign pg      = off >> PAGE_SHIFT;
    assign aligned = (va[PAGE_SHIFT-1:0] == '0);
    assign in_win  = (va >= VBASE) && (pg < VA_W'(NUM_ENT));
    assign ok      = aligned && in_win;
    assign idx     = pg[IDX_W-1:0];

endmodule

// File: rtl/ptt_xlate.sv
module ptt_xlate
    import ptt_pkg::*;
#(
    parameter int              PFN_W      = 9,
    parameter int              PAGE_SHIFT = 12,
    parameter int              PA_W       = 32,
    parameter logic [PA_W-1:0] MEM_BASE   = 32'hBE00_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            addr_ok,
    input  logic [PFN_W:0]  word,
    output logic            rsp_valid,
    output xl_status_e      rsp_status,
    output logic [PA_W-1:0] rsp_pa
);

    typedef struct packed {
        xl_status_e      st;
        logic [PA_W-1:0] pa;
    } xl_res_t;

    xl_res_t         nxt;
    logic [PA_W-1:0] pfn_ext;

    assign pfn_ext = PA_W'(word[PFN_W-1:0]);

    always_comb begin
        nxt = '{st: ST_OK, pa: '0};
        if (!addr_ok)          nxt.st = ST_BADADDR;
        else if (!word[PFN_W]) nxt.st = ST_UNMAPPED;
        else                   nxt.pa = MEM_BASE + (pfn_ext << PAGE_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_pa     <= '0;
        end else begin
            rsp_valid  <= req;
            rsp_status <= req ? nxt.st : ST_OK;
            rsp_pa     <= req ? nxt.pa : '0;
        end
    end

endmodule

// File: rtl/page_xlate_table.sv
module page_xlate_table
    import ptt_pkg::*;
#(
    parameter int              NUM_ENT    = 64,
    parameter int              PFN_W      = 9,
    parameter int              PAGE_SHIFT = 12,
    parameter int              VA_W       = 32,
    parameter int              PA_W       = 32,
    parameter int              RIDX_W     = 8,
    parameter int              FLAG_W     = 4,
    parameter logic [VA_W-1:0] VBASE      = 32'hA000_0000,
    parameter logic [PA_W-1:0] MEM_BASE   = 32'hBE00_0000,
    localparam int             IDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_op,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [PA_W-1:0]   reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [FLAG_W-1:0] rsp_flags
);

    logic             va_ok;
    logic [IDX_W-1:0] va_idx;
    logic [PFN_W:0]   lk_word;
    entry_t           rd_word;
    xl_status_e       st;

    ptt_vcheck #(
        .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENT(NUM_ENT), .VBASE(VBASE)
    ) u_vchk (
        .va(lk_va), .ok(va_ok), .idx(va_idx)
    );

    ptt_store #(
        .NUM_ENT(NUM_ENT), .PFN_W(PFN_W), .PAGE_SHIFT(PAGE_SHIFT),
        .PA_W(PA_W), .RIDX_W(RIDX_W)
    ) u_store (
        .clk(clk), .rst(rst), .op(reg_op_e'(reg_op)), .idx(reg_idx),
        .wdata(reg_wdata), .rdata(rd_word), .lk_idx(va_idx), .lk_word(lk_word)
    );

    ptt_xlate #(
        .PFN_W(PFN_W), .PAGE_SHIFT(PAGE_SHIFT), .PA_W(PA_W), .MEM_BASE(MEM_BASE)
    ) u_xl (
        .clk(clk), .rst(rst), .req(lk_valid), .addr_ok(va_ok), .word(lk_word),
        .rsp_valid(rsp_valid), .rsp_status(st), .rsp_pa(rsp_pa)
    );

    assign reg_rdata  = rd_word;
    assign rsp_status = st;
    assign rsp_flags  = '0;

endmodule

// File: rtl/ptt_chk.sv
module ptt_chk #(
    parameter int              NUM_ENT    = 64,
    parameter int              PAGE_SHIFT = 12,
    parameter int              VA_W       = 32,
    parameter int              PA_W       = 32,
    parameter int              RIDX_W     = 8,
    parameter int              FLAG_W     = 4,
    parameter logic [PA_W-1:0] MEM_BASE   = 32'hBE00_0000
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        reg_op,
    input logic [RIDX_W-1:0] reg_idx,
    input logic [15:0]       reg_rdata,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_va,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [PA_W-1:0]   rsp_pa,
    input logic [FLAG_W-1:0] rsp_flags
);

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    a_r9_flags_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_flags == '0);

    a_r7_fault_no_pa: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'd0) |-> rsp_pa == '0);

    a_r6_pa_in_memory: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd0) |->
            (rsp_pa[PAGE_SHIFT-1:0] == '0 && rsp_pa >= MEM_BASE));

    a_r8_misaligned: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_va[PAGE_SHIFT-1:0] != '0) |=> rsp_status == 2'd1);

    a_r11_oob_read: assert property (@(posedge clk) disable iff (rst)
        (reg_op == 3'd1 && int'(reg_idx) >= NUM_ENT) |=> reg_rdata == '0);

endmodule

bind page_xlate_table ptt_chk #(
    .NUM_ENT(NUM_ENT), .PAGE_SHIFT(PAGE_SHIFT), .VA_W(VA_W), .PA_W(PA_W),
    .RIDX_W(RIDX_W), .FLAG_W(FLAG_W), .MEM_BASE(MEM_BASE)
) u_chk (
    .clk(clk), .rst(rst), .reg_op(reg_op), .reg_idx(reg_idx),
    .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
    .rsp_flags(rsp_flags)
);

// File: tb/sim_page_xlate_table.sv
module sim_page_xlate_table;

    localparam int          CLK_PERIOD = 10;
    localparam int          NE  = 32;
    localparam int          PFN = 9;
    localparam int          SH  = 12;
    localparam logic [31:0] VB  = 32'h4000_0000;
    localparam logic [31:0] MB  = 32'hBE00_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_op = 3'd0;
    logic [7:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_table #(
        .NUM_ENT(NE), .PFN_W(PFN), .PAGE_SHIFT(SH), .VA_W(32), .PA_W(32),
        .RIDX_W(8), .FLAG_W(4), .VBASE(VB), .MEM_BASE(MB)
    ) u0 (
        .clk(clk), .rst(rst), .reg_op(reg_op), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_va(lk_va), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_pa(rsp_pa), .rsp_flags(rsp_flags)
    );

    typedef struct {
        logic [1:0]  st;
        logic [31:0] pa;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] model [NE];
    int          n_chk = 0;
    int          n_bad = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [31:0] va, input string tag);
        exp_t r;
        logic [15:0] e;
        r.tag = tag;
        r.pa  = '0;
        if (va[SH-1:0] != '0 || va < VB || va >= VB + (NE << SH)) begin
            r.st = 2'd1;
        end else begin
            e = model[(va - VB) >> SH];
            if (!e[PFN]) r.st = 2'd2;
            else begin
                r.st = 2'd0;
                r.pa = MB + ({23'b0, e[PFN-1:0]} << SH);
            end
        end
        return r;
    endfunction

    // one cycle of stimulus; expectations come from the bench model
    task automatic cyc(input logic [2:0] op, input int idx, input logic [31:0] wd,
                       input logic lv, input logic [31:0] va, input string tag);
        logic [15:0] rexp;
        logic [15:0] e;
        reg_op    = op;
        reg_idx   = 8'(idx);
        reg_wdata = wd;
        lk_valid  = lv;
        lk_va     = va;
        if (lv) sb.push_back(predict(va, tag));
        rexp = (idx < NE) ? model[idx] : 16'h0;
        if (idx < NE) begin
            case (op)
                3'd2: model[idx] = wd[15:0];
                3'd3: begin
                    e = '0;
                    e[PFN-1:0] = wd[SH +: PFN];
                    e[PFN] = 1'b1;
                    model[idx] = e;
                end
                3'd4: model[idx][PFN] = 1'b0;
                default: ;
            endcase
        end
        @(negedge clk);
        if (op == 3'd1)
            check(reg_rdata === rexp, tag, {16'h0, reg_rdata}, {16'h0, rexp});
        reg_op   = 3'd0;
        lk_valid = 1'b0;
    endtask

    task automatic rd(input int idx, input string tag);
        cyc(3'd1, idx, 32'h0, 1'b0, 32'h0, tag);
    endtask

    task automatic lk(input logic [31:0] va, input string tag);
        cyc(3'd0, 0, 32'h0, 1'b1, va, tag);
    endtask

    // monitor: pops scoreboard items as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected response", {31'h0, rsp_valid}, 32'h0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(rsp_status === x.st, {x.tag, " status"}, {30'h0, rsp_status}, {30'h0, x.st});
                check(rsp_pa === x.pa, {x.tag, " pa"}, rsp_pa, x.pa);
                check(rsp_flags === 4'h0, "R9 flags", {28'h0, rsp_flags}, 32'h0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rsp_valid === 1'b0, "R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check(reg_rdata === 16'h0, "R1 reset rdata", {16'h0, reg_rdata}, 32'h0);

        // R1: cleared table
        rd(0, "R1 read idx0");
        rd(31, "R1 read idx31");
        lk(VB, "R1 lookup unmapped");
        lk(VB + (32'd17 << SH), "R1 lookup unmapped 17");

        // R2: raw word and idle op
        cyc(3'd2, 3, 32'h0000_A5F3, 1'b0, 32'h0, "R2 write");
        rd(3, "R2 read back");
        cyc(3'd0, 3, 32'h0000_FFFF, 1'b0, 32'h0, "R2 idle op");
        rd(3, "R2 idle leaves word");
        lk(VB + (32'd3 << SH), "R7 raw word enable clear");

        // R3: map and truncation of page number
        cyc(3'd3, 4, MB + 32'h7000, 1'b0, 32'h0, "R3 map");
        rd(4, "R3 map word");
        lk(VB + (32'd4 << SH), "R6 translate idx4");
        cyc(3'd3, 5, 32'h9E1F_5000, 1'b0, 32'h0, "R3 map truncate");
        rd(5, "R3 truncated word");
        lk(VB + (32'd5 << SH), "R6 translate alias");

        // R4: unmap clears enable only
        cyc(3'd2, 6, 32'h0000_FFFF, 1'b0, 32'h0, "R4 prep");
        cyc(3'd4, 6, 32'h0, 1'b0, 32'h0, "R4 unmap");
        rd(6, "R4 unmap keeps bits");
        cyc(3'd4, 4, 32'h0, 1'b0, 32'h0, "R4 unmap mapped");
        rd(4, "R4 field kept");
        lk(VB + (32'd4 << SH), "R7 after unmap");

        // R6: bits above enable ignored
        cyc(3'd2, 12, 32'h0000_F215, 1'b0, 32'h0, "R6 raw high bits");
        lk(VB + (32'd12 << SH), "R6 high bits ignored");

        // R5/R6: whole table
        for (int i = 0; i < NE; i++)
            cyc(3'd3, i, MB + (32'(i * 7 + 1) << SH), 1'b0, 32'h0, "R5 fill");
        for (int i = 0; i < NE; i++)
            lk(VB + (32'(i) << SH), "R5 index sweep");

        // R8: address rejection
        lk(VB + 32'h10, "R8 misaligned");
        lk(VB + (32'd2 << SH) + 32'h800, "R8 misaligned mid");
        lk(VB - 32'h1000, "R8 below base");
        lk(VB + (32'(NE) << SH), "R8 past window");
        lk(VB + (32'(NE - 1) << SH), "R8 last page ok");

        // R10: same-cycle write sees old word; next cycle sees new
        cyc(3'd3, 10, MB + 32'h1AB000, 1'b1, VB + (32'd10 << SH), "R10 same cycle old");
        lk(VB + (32'd10 << SH), "R10 next cycle new");
        cyc(3'd4, 10, 32'h0, 1'b1, VB + (32'd10 << SH), "R10 unmap same cycle");
        lk(VB + (32'd10 << SH), "R10 unmap seen");

        // R11: out-of-range register index
        cyc(3'd2, 40, 32'h0000_1234, 1'b0, 32'h0, "R11 oob write");
        cyc(3'd4, 40, 32'h0, 1'b0, 32'h0, "R11 oob unmap");
        rd(8, "R11 alias untouched");
        rd(40, "R11 oob read zero");
        lk(VB + (32'd8 << SH), "R11 alias still mapped");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R10 all responses seen", 32'(sb.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule